// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Request Thresholds

This block sits between a bus-side sample port and a serial audio engine. It holds one transmit FIFO that the bus fills and the engine drains at each outgoing sample slot, and one receive FIFO that the engine fills at each incoming sample slot and the bus drains. Each direction raises a DMA request from its own fill level compared against a programmable 4-bit threshold. The sizing is such that a 16-sample burst always fits when the transmit request is high. Both directions share one data-port address on the bus side, so the two FIFOs are reached through separate write and read strobes.

Each direction has an enable and a DMA enable. Sticky underrun and overrun flags are cleared by write-one strobes. There is an option that repeats the last transmitted sample when the transmit FIFO runs dry. Each FIFO has a flush command that clears itself once that FIFO is empty. A build-time variant lets the transmit flush empty both FIFOs. A configuration reset strobe puts every setting, flag and FIFO back to its default state without the hard reset.

Top module: `aud_dma_fifo`

## Requirements
- R1: After hard reset or a `cfg_reset` strobe, the thresholds are 8 (transmit) and 7 (receive), and all enables, DMA enables, the replay option and the interrupt enables are 0. Both FIFOs are empty, both flags and both flush bits are 0, and `ser_tx_sample` and `bus_rd_data` are 0. A `cfg_reset` overrides a configuration write in the same cycle.
- R2: `cfg_thr_we` loads both thresholds and `cfg_ctl_we` loads the enables, replay option and interrupt enables. Either load takes effect from the next cycle.
- R3: A `bus_wr_valid` stores `bus_wr_data` in the 32-entry transmit FIFO unless that FIFO is full or flushing, in which case the word is dropped. Words leave in the order they arrived.
- R4: On `ser_tx_slot` with transmit enabled and data present, the oldest word appears on `ser_tx_sample` after that edge. With transmit disabled, the slot outputs 0, removes nothing and flags nothing.
- R5: On `ser_tx_slot` with transmit enabled and the FIFO empty or flushing, `underrun_flag` is set. The output is the last word taken from the FIFO if the replay option is set, and 0 otherwise.
- R6: On `ser_rx_slot` with receive enabled, `ser_rx_sample` is stored in the receive FIFO. A `bus_rd_req` places the oldest receive word on `bus_rd_data` after that edge, or 0 if the FIFO is empty or flushing.
- R7: On `ser_rx_slot` with receive enabled and the receive FIFO full, the sample is dropped and `overrun_flag` is set.
- R8: Each flag stays set until its clear strobe (`clr_underrun`, `clr_overrun`). A set event in the same cycle as the clear leaves the flag set.
- R9: `tx_dma_req` is high exactly when transmit enable and transmit DMA enable are 1, the transmit FIFO is not flushing, and its level is at or below the transmit threshold.
- R10: `rx_dma_req` is high exactly when receive enable and receive DMA enable are 1, the receive FIFO is not flushing, and its level is nonzero and at or above the receive threshold.
- R11: `irq` is the OR of four terms, each masked by one bit of `cfg_irq_en`. Bit 0 masks the overrun flag and bit 1 masks the underrun flag. Bit 2 masks the receive service condition, which is R10 without the DMA enable. Bit 3 masks the transmit service condition, which is R9 without the DMA enable.
- R12: A flush command sets that FIFO's flush bit at the next edge. While the bit is set, the FIFO's contents are discarded at each edge, it accepts nothing, and it reads as empty. The bit clears at the first edge where the FIFO is empty.
- R13: With `SHARED_FLUSH` = 1, `tx_flush_cmd` flushes both FIFOs and `rx_flush_cmd` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reset | input | 1 | Configuration reset strobe |
| cfg_thr_we | input | 1 | Load both thresholds |
| cfg_tx_thr | input | THR_W | Transmit threshold value |
| cfg_rx_thr | input | THR_W | Receive threshold value |
| cfg_ctl_we | input | 1 | Load enables, replay option, interrupt enables |
| cfg_tx_en | input | 1 | Transmit direction enable |
| cfg_rx_en | input | 1 | Receive direction enable |
| cfg_tx_dma_en | input | 1 | Transmit DMA request enable |
| cfg_rx_dma_en | input | 1 | Receive DMA request enable |
| cfg_play_last | input | 1 | Replay last sample on underrun |
| cfg_irq_en | input | 4 | Interrupt enables (bit map in R11) |
| tx_flush_cmd | input | 1 | Transmit flush command |
| rx_flush_cmd | input | 1 | Receive flush command |
| clr_underrun | input | 1 | Clear underrun flag |
| clr_overrun | input | 1 | Clear overrun flag |
| bus_wr_valid | input | 1 | Bus write to transmit FIFO |
| bus_wr_data | input | DATA_W | Bus write word |
| bus_rd_req | input | 1 | Bus read from receive FIFO |
| bus_rd_data | output | DATA_W | Bus read word |
| ser_tx_slot | input | 1 | Engine wants an outgoing sample |
| ser_tx_sample | output | DATA_W | Outgoing sample |
| ser_rx_slot | input | 1 | Engine delivers an incoming sample |
| ser_rx_sample | input | DATA_W | Incoming sample |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_flushing | output | 1 | Transmit flush bit |
| rx_flushing | output | 1 | Receive flush bit |
| underrun_flag | output | 1 | Sticky transmit underrun |
| overrun_flag | output | 1 | Sticky receive overrun |
| irq | output | 1 | Interrupt request |

## Verification
The interesting collision is a transmit slot that finds the FIFO empty in the same cycle as the write-one clear of the underrun flag. The bench provokes it by draining the FIFO and then raising `ser_tx_slot` and `clr_underrun` together, and it expects the flag to stay set. A second collision is a bus write that arrives while a flush is still in progress. That word must be lost, which the bench judges from the replayed sample that the next empty slot returns. The behavioural queue model follows both collisions every cycle alongside these directed checks.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;

  typedef struct packed {
    logic       tx_en;
    logic       rx_en;
    logic       tx_dma_en;
    logic       rx_dma_en;
    logic       play_last;
    logic [3:0] irq_en;
  } aud_ctl_t;

  localparam int IRQ_OVR = 0;
  localparam int IRQ_UND = 1;
  localparam int IRQ_RXS = 2;
  localparam int IRQ_TXS = 3;

  // transmit side wants refilling while its level is at or under the threshold
  function automatic logic tx_wants_fill(input int unsigned level, input int unsigned thr);
    return level <= thr;
  endfunction

  // receive side wants draining while it holds data at or over the threshold
  function automatic logic rx_wants_drain(input int unsigned level, input int unsigned thr);
    return (level != 0) && (level >= thr);
  endfunction

endpackage

// File: rtl/aud_sfifo.sv
module aud_sfifo #(
  parameter  int W     = 16,
  parameter  int DEPTH = 32,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp;
  logic [PW-1:0] rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign head = mem[rp];

endmodule

// File: rtl/aud_flush_ctl.sv
module aud_flush_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_reset,
  input  logic cmd,
  input  logic empty,
  output logic busy
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (cfg_reset) busy <= 1'b0;
    else if (cmd)       busy <= 1'b1;
    else if (empty)     busy <= 1'b0;
  end

endmodule

// File: rtl/aud_sticky.sv
module aud_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_reset,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (cfg_reset) flag <= 1'b0;
    else if (set)       flag <= 1'b1;
    else if (clr)       flag <= 1'b0;
  end

endmodule

// File: rtl/aud_cfg_regs.sv
module aud_cfg_regs
  import aud_fifo_pkg::*;
#(
  parameter int THR_W      = 4,
  parameter int TX_THR_RST = 8,
  parameter int RX_THR_RST = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_reset,
  input  logic             thr_we,
  input  logic [THR_W-1:0] tx_thr_in,
  input  logic [THR_W-1:0] rx_thr_in,
  input  logic             ctl_we,
  input  aud_ctl_t         ctl_in,
  output logic [THR_W-1:0] tx_thr,
  output logic [THR_W-1:0] rx_thr,
  output aud_ctl_t         ctl
);

  localparam logic [THR_W-1:0] TX_RST = THR_W'(TX_THR_RST);
  localparam logic [THR_W-1:0] RX_RST = THR_W'(RX_THR_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr <= TX_RST;
      rx_thr <= RX_RST;
      ctl    <= '0;
    end else if (cfg_reset) begin
      tx_thr <= TX_RST;
      rx_thr <= RX_RST;
      ctl    <= '0;
    end else begin
      if (thr_we) begin
        tx_thr <= tx_thr_in;
        rx_thr <= rx_thr_in;
      end
      if (ctl_we) ctl <= ctl_in;
    end
  end

endmodule

// File: rtl/aud_dma_fifo.sv
module aud_dma_fifo
  import aud_fifo_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int DEPTH        = 32,
  parameter int THR_W        = 4,
  parameter int TX_THR_RST   = 8,
  parameter int RX_THR_RST   = 7,
  parameter int SHARED_FLUSH = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_reset,
  input  logic              cfg_thr_we,
  input  logic [THR_W-1:0]  cfg_tx_thr,
  input  logic [THR_W-1:0]  cfg_rx_thr,
  input  logic              cfg_ctl_we,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_en,
  input  logic              cfg_tx_dma_en,
  input  logic              cfg_rx_dma_en,
  input  logic              cfg_play_last,
  input  logic [3:0]        cfg_irq_en,
  input  logic              tx_flush_cmd,
  input  logic              rx_flush_cmd,
  input  logic              clr_underrun,
  input  logic              clr_overrun,
  input  logic              bus_wr_valid,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_req,
  output logic [DATA_W-1:0] bus_rd_data,
  input  logic              ser_tx_slot,
  output logic [DATA_W-1:0] ser_tx_sample,
  input  logic              ser_rx_slot,
  input  logic [DATA_W-1:0] ser_rx_sample,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              tx_flushing,
  output logic              rx_flushing,
  output logic              underrun_flag,
  output logic              overrun_flag,
  output logic              irq
);

  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  // configuration state
  aud_ctl_t         ctl_in;
  aud_ctl_t         ctl;
  logic [THR_W-1:0] tx_thr;
  logic [THR_W-1:0] rx_thr;

  assign ctl_in = '{tx_en:     cfg_tx_en,
                    rx_en:     cfg_rx_en,
                    tx_dma_en: cfg_tx_dma_en,
                    rx_dma_en: cfg_rx_dma_en,
                    play_last: cfg_play_last,
                    irq_en:    cfg_irq_en};

  aud_cfg_regs #(
    .THR_W      (THR_W),
    .TX_THR_RST (TX_THR_RST),
    .RX_THR_RST (RX_THR_RST)
  ) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_reset (cfg_reset),
    .thr_we    (cfg_thr_we),
    .tx_thr_in (cfg_tx_thr),
    .rx_thr_in (cfg_rx_thr),
    .ctl_we    (cfg_ctl_we),
    .ctl_in    (ctl_in),
    .tx_thr    (tx_thr),
    .rx_thr    (rx_thr),
    .ctl       (ctl)
  );

  // named internal events (also used by the bound checker)
  logic [CW-1:0]     tx_lvl;
  logic [CW-1:0]     rx_lvl;
  logic [DATA_W-1:0] tx_head;
  logic [DATA_W-1:0] rx_head;
  logic              tx_seen_empty;
  logic              rx_seen_empty;
  logic              tx_push;
  logic              tx_pop;
  logic              rx_push;
  logic              rx_pop;
  logic              tx_underrun_ev;
  logic              rx_overrun_ev;
  logic              rx_flush_go;
  logic              tx_svc;
  logic              rx_svc;

  assign tx_seen_empty  = tx_flushing || (tx_lvl == '0);
  assign rx_seen_empty  = rx_flushing || (rx_lvl == '0);

  assign tx_push        = bus_wr_valid && !tx_flushing && (tx_lvl != FULL_LVL);
  assign tx_pop         = ser_tx_slot && ctl.tx_en && !tx_seen_empty;
  assign tx_underrun_ev = ser_tx_slot && ctl.tx_en && tx_seen_empty;

  assign rx_push        = ser_rx_slot && ctl.rx_en && !rx_flushing && (rx_lvl != FULL_LVL);
  assign rx_overrun_ev  = ser_rx_slot && ctl.rx_en && !rx_flushing && (rx_lvl == FULL_LVL);
  assign rx_pop         = bus_rd_req && !rx_seen_empty;

  // flush routing: the variant parameter picks split or shared commands
  generate
    if (SHARED_FLUSH != 0) begin : g_shared_flush
      assign rx_flush_go = tx_flush_cmd;
    end else begin : g_split_flush
      assign rx_flush_go = rx_flush_cmd;
    end
  endgenerate

  aud_flush_ctl tx_flush_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_reset (cfg_reset),
    .cmd       (tx_flush_cmd),
    .empty     (tx_lvl == '0),
    .busy      (tx_flushing)
  );

  aud_flush_ctl rx_flush_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_reset (cfg_reset),
    .cmd       (rx_flush_go),
    .empty     (rx_lvl == '0),
    .busy      (rx_flushing)
  );

  // storage
  aud_sfifo #(.W(DATA_W), .DEPTH(DEPTH)) tx_fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_reset || tx_flushing),
    .push  (tx_push),
    .pop   (tx_pop),
    .din   (bus_wr_data),
    .head  (tx_head),
    .level (tx_lvl)
  );

  aud_sfifo #(.W(DATA_W), .DEPTH(DEPTH)) rx_fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_reset || rx_flushing),
    .push  (rx_push),
    .pop   (rx_pop),
    .din   (ser_rx_sample),
    .head  (rx_head),
    .level (rx_lvl)
  );

  // sticky status
  aud_sticky und_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_reset (cfg_reset),
    .set       (tx_underrun_ev),
    .clr       (clr_underrun),
    .flag      (underrun_flag)
  );

  aud_sticky ovr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_reset (cfg_reset),
    .set       (rx_overrun_ev),
    .clr       (clr_overrun),
    .flag      (overrun_flag)
  );

  // sample output registers
  logic [DATA_W-1:0] last_sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_tx_sample <= '0;
      last_sample   <= '0;
      bus_rd_data   <= '0;
    end else if (cfg_reset) begin
      ser_tx_sample <= '0;
      last_sample   <= '0;
      bus_rd_data   <= '0;
    end else begin
      if (ser_tx_slot) begin
        if (!ctl.tx_en)     ser_tx_sample <= '0;
        else if (tx_pop)    ser_tx_sample <= tx_head;
        else                ser_tx_sample <= ctl.play_last ? last_sample : '0;
      end
      if (tx_pop)     last_sample <= tx_head;
      if (bus_rd_req) bus_rd_data <= rx_pop ? rx_head : '0;
    end
  end

  // requests and interrupt
  assign tx_svc     = ctl.tx_en && !tx_flushing && tx_wants_fill(int'(tx_lvl), int'(tx_thr));
  assign rx_svc     = ctl.rx_en && !rx_flushing && rx_wants_drain(int'(rx_lvl), int'(rx_thr));
  assign tx_dma_req = tx_svc && ctl.tx_dma_en;
  assign rx_dma_req = rx_svc && ctl.rx_dma_en;

  assign irq = (overrun_flag  && ctl.irq_en[IRQ_OVR]) ||
               (underrun_flag && ctl.irq_en[IRQ_UND]) ||
               (rx_svc        && ctl.irq_en[IRQ_RXS]) ||
               (tx_svc        && ctl.irq_en[IRQ_TXS]);

endmodule

// File: rtl/aud_dma_fifo_chk.sv
module aud_dma_fifo_chk #(
  parameter int DEPTH        = 32,
  parameter int CW           = 6,
  parameter int SHARED_FLUSH = 0,
  parameter int BURST        = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_reset,
  input logic          tx_flush_cmd,
  input logic          clr_underrun,
  input logic          tx_flushing,
  input logic          rx_flushing,
  input logic          underrun_flag,
  input logic          overrun_flag,
  input logic          tx_dma_req,
  input logic          rx_dma_req,
  input logic          tx_underrun_ev,
  input logic          rx_overrun_ev,
  input logic          tx_pop,
  input logic [CW-1:0] tx_lvl,
  input logic [CW-1:0] rx_lvl
);

  a_r1_cfg_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |=> (tx_lvl == '0) && (rx_lvl == '0) && !underrun_flag && !overrun_flag
                  && !tx_flushing && !rx_flushing);

  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_lvl) <= DEPTH) && (int'(rx_lvl) <= DEPTH));

  a_r5_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun_ev && !cfg_reset |=> underrun_flag);

  a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun_ev && !cfg_reset |=> overrun_flag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_flag && !clr_underrun && !cfg_reset |=> underrun_flag);

  a_r9_burst_room: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> (DEPTH - int'(tx_lvl)) >= BURST);

  a_r10_rx_req_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> (rx_lvl != '0));

  a_r12_flush_discards: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flushing && !cfg_reset |=> (tx_lvl == '0));

  a_r12_no_pop_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flushing |-> !tx_pop);

  a_r13_shared_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (SHARED_FLUSH != 0) && tx_flush_cmd && !cfg_reset |=> rx_flushing);

endmodule

bind aud_dma_fifo aud_dma_fifo_chk #(
  .DEPTH        (DEPTH),
  .CW           (CW),
  .SHARED_FLUSH (SHARED_FLUSH)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_reset      (cfg_reset),
  .tx_flush_cmd   (tx_flush_cmd),
  .clr_underrun   (clr_underrun),
  .tx_flushing    (tx_flushing),
  .rx_flushing    (rx_flushing),
  .underrun_flag  (underrun_flag),
  .overrun_flag   (overrun_flag),
  .tx_dma_req     (tx_dma_req),
  .rx_dma_req     (rx_dma_req),
  .tx_underrun_ev (tx_underrun_ev),
  .rx_overrun_ev  (rx_overrun_ev),
  .tx_pop         (tx_pop),
  .tx_lvl         (tx_lvl),
  .rx_lvl         (rx_lvl)
);

// File: tb/aud_dma_fifo_tb_top.sv
module aud_dma_fifo_tb_top;

  localparam int DW    = 16;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          cfg_reset, cfg_thr_we, cfg_ctl_we;
  logic [3:0]    cfg_tx_thr, cfg_rx_thr, cfg_irq_en;
  logic          cfg_tx_en, cfg_rx_en, cfg_tx_dma_en, cfg_rx_dma_en, cfg_play_last;
  logic          tx_flush_cmd, rx_flush_cmd, clr_underrun, clr_overrun;
  logic          bus_wr_valid, bus_rd_req, ser_tx_slot, ser_rx_slot;
  logic [DW-1:0] bus_wr_data, ser_rx_sample;

  logic [DW-1:0] bus_rd_data, ser_tx_sample;
  logic tx_dma_req, rx_dma_req, tx_flushing, rx_flushing, underrun_flag, overrun_flag, irq;
  logic [DW-1:0] s_bus_rd_data, s_ser_tx_sample;
  logic s_tx_dma_req, s_rx_dma_req, s_tx_flushing, s_rx_flushing, s_und, s_ovr, s_irq;

  aud_dma_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk, .rst_n, .cfg_reset, .cfg_thr_we, .cfg_tx_thr, .cfg_rx_thr, .cfg_ctl_we,
    .cfg_tx_en, .cfg_rx_en, .cfg_tx_dma_en, .cfg_rx_dma_en, .cfg_play_last, .cfg_irq_en,
    .tx_flush_cmd, .rx_flush_cmd, .clr_underrun, .clr_overrun,
    .bus_wr_valid, .bus_wr_data, .bus_rd_req, .bus_rd_data,
    .ser_tx_slot, .ser_tx_sample, .ser_rx_slot, .ser_rx_sample,
    .tx_dma_req, .rx_dma_req, .tx_flushing, .rx_flushing,
    .underrun_flag, .overrun_flag, .irq);

  aud_dma_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .SHARED_FLUSH(1)) dut_s_i (
    .clk, .rst_n, .cfg_reset, .cfg_thr_we, .cfg_tx_thr, .cfg_rx_thr, .cfg_ctl_we,
    .cfg_tx_en, .cfg_rx_en, .cfg_tx_dma_en, .cfg_rx_dma_en, .cfg_play_last, .cfg_irq_en,
    .tx_flush_cmd, .rx_flush_cmd, .clr_underrun, .clr_overrun,
    .bus_wr_valid, .bus_wr_data, .bus_rd_req, .bus_rd_data(s_bus_rd_data),
    .ser_tx_slot, .ser_tx_sample(s_ser_tx_sample), .ser_rx_slot, .ser_rx_sample,
    .tx_dma_req(s_tx_dma_req), .rx_dma_req(s_rx_dma_req),
    .tx_flushing(s_tx_flushing), .rx_flushing(s_rx_flushing),
    .underrun_flag(s_und), .overrun_flag(s_ovr), .irq(s_irq));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model (split-flush instance) ----------------
  logic [DW-1:0] m_txq[$];
  logic [DW-1:0] m_rxq[$];
  int            m_txthr, m_rxthr;
  bit            m_txen, m_rxen, m_txdma, m_rxdma, m_pl;
  logic [3:0]    m_ie;
  bit            m_und, m_ovr, m_txf, m_rxf;
  logic [DW-1:0] m_last, m_txs, m_rd;

  task automatic m_defaults();
    m_txq.delete(); m_rxq.delete();
    m_txthr = 8; m_rxthr = 7;
    m_txen = 0; m_rxen = 0; m_txdma = 0; m_rxdma = 0; m_pl = 0; m_ie = '0;
    m_und = 0; m_ovr = 0; m_txf = 0; m_rxf = 0;
    m_last = '0; m_txs = '0; m_rd = '0;
  endtask

  always @(posedge clk) begin : model
    int tl, rl;
    bit txf0, rxf0, und_set, ovr_set;
    if (!rst_n || cfg_reset) m_defaults();
    else begin
      tl = m_txq.size(); rl = m_rxq.size();
      txf0 = m_txf; rxf0 = m_rxf; und_set = 0; ovr_set = 0;
      if (ser_tx_slot) begin
        if (!m_txen) m_txs = '0;
        else if (!txf0 && tl > 0) begin m_txs = m_txq.pop_front(); m_last = m_txs; end
        else begin m_txs = m_pl ? m_last : '0; und_set = 1; end
      end
      if (bus_wr_valid && !txf0 && tl < DEPTH) m_txq.push_back(bus_wr_data);
      if (txf0) m_txq.delete();
      m_txf = tx_flush_cmd ? 1'b1 : (txf0 && tl != 0);
      if (bus_rd_req) begin
        if (!rxf0 && rl > 0) m_rd = m_rxq.pop_front();
        else m_rd = '0;
      end
      if (ser_rx_slot && m_rxen && !rxf0) begin
        if (rl < DEPTH) m_rxq.push_back(ser_rx_sample);
        else ovr_set = 1;
      end
      if (rxf0) m_rxq.delete();
      m_rxf = rx_flush_cmd ? 1'b1 : (rxf0 && rl != 0);
      m_und = und_set ? 1'b1 : (clr_underrun ? 1'b0 : m_und);
      m_ovr = ovr_set ? 1'b1 : (clr_overrun ? 1'b0 : m_ovr);
      if (cfg_thr_we) begin m_txthr = int'(cfg_tx_thr); m_rxthr = int'(cfg_rx_thr); end
      if (cfg_ctl_we) begin
        m_txen = cfg_tx_en; m_rxen = cfg_rx_en; m_txdma = cfg_tx_dma_en;
        m_rxdma = cfg_rx_dma_en; m_pl = cfg_play_last; m_ie = cfg_irq_en;
      end
    end
  end

  always @(negedge clk) begin : compare
    bit txc, rxc, e_irq;
    if (rst_n) begin
      txc = m_txen && !m_txf && (m_txq.size() <= m_txthr);
      rxc = m_rxen && !m_rxf && (m_rxq.size() > 0) && (m_rxq.size() >= m_rxthr);
      e_irq = (m_ovr && m_ie[0]) || (m_und && m_ie[1]) || (rxc && m_ie[2]) || (txc && m_ie[3]);
      chk(ser_tx_sample == m_txs, "R4/R5 model ser_tx_sample", ser_tx_sample, m_txs);
      chk(bus_rd_data == m_rd, "R6 model bus_rd_data", bus_rd_data, m_rd);
      chk(tx_dma_req == (txc && m_txdma), "R9 model tx_dma_req", tx_dma_req, txc && m_txdma);
      chk(rx_dma_req == (rxc && m_rxdma), "R10 model rx_dma_req", rx_dma_req, rxc && m_rxdma);
      chk(tx_flushing == m_txf, "R12 model tx_flushing", tx_flushing, m_txf);
      chk(rx_flushing == m_rxf, "R12 model rx_flushing", rx_flushing, m_rxf);
      chk(underrun_flag == m_und, "R8 model underrun_flag", underrun_flag, m_und);
      chk(overrun_flag == m_ovr, "R7 model overrun_flag", overrun_flag, m_ovr);
      chk(irq == e_irq, "R11 model irq", irq, e_irq);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctl(input bit te, input bit re, input bit td, input bit rd, input bit pl,
                         input logic [3:0] ie);
    cfg_tx_en = te; cfg_rx_en = re; cfg_tx_dma_en = td; cfg_rx_dma_en = rd;
    cfg_play_last = pl; cfg_irq_en = ie; cfg_ctl_we = 1;
    cyc(); cfg_ctl_we = 0;
  endtask

  task automatic set_thr(input logic [3:0] t, input logic [3:0] r);
    cfg_tx_thr = t; cfg_rx_thr = r; cfg_thr_we = 1;
    cyc(); cfg_thr_we = 0;
  endtask

  task automatic wr_tx(input logic [DW-1:0] d);
    bus_wr_valid = 1; bus_wr_data = d;
    cyc(); bus_wr_valid = 0;
  endtask

  task automatic slot();
    ser_tx_slot = 1;
    cyc(); ser_tx_slot = 0;
  endtask

  task automatic rx_in(input logic [DW-1:0] d);
    ser_rx_slot = 1; ser_rx_sample = d;
    cyc(); ser_rx_slot = 0;
  endtask

  task automatic rd();
    bus_rd_req = 1;
    cyc(); bus_rd_req = 0;
  endtask

  task automatic pulse_cfg_reset();
    cfg_reset = 1;
    cyc(); cfg_reset = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin : stim
    rst_n = 0;
    {cfg_reset, cfg_thr_we, cfg_ctl_we, cfg_tx_en, cfg_rx_en, cfg_tx_dma_en, cfg_rx_dma_en} = '0;
    cfg_play_last = 0; cfg_irq_en = '0; cfg_tx_thr = '0; cfg_rx_thr = '0;
    {tx_flush_cmd, rx_flush_cmd, clr_underrun, clr_overrun} = '0;
    {bus_wr_valid, bus_rd_req, ser_tx_slot, ser_rx_slot} = '0;
    bus_wr_data = '0; ser_rx_sample = '0;
    cyc(3);
    rst_n = 1;
    cyc();

    // R1 reset state
    chk(!tx_dma_req && !rx_dma_req && !irq, "R1 reset requests/irq low", {tx_dma_req, rx_dma_req, irq}, 0);
    chk(ser_tx_sample == 0 && bus_rd_data == 0, "R1 reset outputs zero", ser_tx_sample, 0);

    // R1/R2 default transmit threshold 8 observed via request
    set_ctl(1, 0, 1, 0, 0, 4'b0000);
    chk(tx_dma_req == 1, "R2 tx request after ctl load", tx_dma_req, 1);
    for (int i = 0; i < 8; i++) wr_tx(16'h0100 + 16'(i));
    chk(tx_dma_req == 1, "R1 default tx threshold 8, level 8", tx_dma_req, 1);
    wr_tx(16'h0108);
    chk(tx_dma_req == 0, "R9 level 9 above threshold 8", tx_dma_req, 0);

    // R4 ordered output
    slot();
    chk(ser_tx_sample == 16'h0100, "R4 first sample", ser_tx_sample, 16'h0100);
    slot();
    chk(ser_tx_sample == 16'h0101, "R4 second sample", ser_tx_sample, 16'h0101);

    // R4 disabled slot
    set_ctl(0, 0, 1, 0, 0, 4'b0000);
    slot();
    chk(ser_tx_sample == 0 && !underrun_flag, "R4 disabled slot outputs 0, no flag", ser_tx_sample, 0);
    set_ctl(1, 0, 1, 0, 0, 4'b0000);
    for (int i = 0; i < 7; i++) slot();
    chk(ser_tx_sample == 16'h0108, "R4 disabled slot removed nothing", ser_tx_sample, 16'h0108);

    // R5 underrun, zero then replay
    slot();
    chk(ser_tx_sample == 0 && underrun_flag, "R5 underrun gives 0 and sets flag", ser_tx_sample, 0);
    set_ctl(1, 0, 1, 0, 1, 4'b0010);
    slot();
    chk(ser_tx_sample == 16'h0108, "R5 replay last sample", ser_tx_sample, 16'h0108);
    chk(irq == 1, "R11 underrun irq bit1", irq, 1);

    // R8 set beats clear in the same cycle, then clear alone
    ser_tx_slot = 1; clr_underrun = 1;
    cyc(); ser_tx_slot = 0; clr_underrun = 0;
    chk(underrun_flag == 1, "R8 set wins over clear", underrun_flag, 1);
    clr_underrun = 1; cyc(); clr_underrun = 0;
    chk(underrun_flag == 0, "R8 clear strobe", underrun_flag, 0);

    // R3 fill to 32, 33rd dropped
    for (int i = 0; i < 33; i++) wr_tx(16'h0200 + 16'(i));
    chk(tx_dma_req == 0, "R9 full FIFO no request", tx_dma_req, 0);
    for (int i = 0; i < 32; i++) slot();
    chk(ser_tx_sample == 16'h021F, "R3 last stored word", ser_tx_sample, 16'h021F);
    slot();
    chk(ser_tx_sample == 16'h021F, "R3 word beyond 32 was dropped", ser_tx_sample, 16'h021F);
    clr_underrun = 1; cyc(); clr_underrun = 0;

    // R12 flush, write during flush lost
    for (int i = 0; i < 3; i++) wr_tx(16'h0300 + 16'(i));
    tx_flush_cmd = 1; cyc(); tx_flush_cmd = 0;
    chk(tx_flushing == 1, "R12 flush bit set", tx_flushing, 1);
    wr_tx(16'h03AA);
    chk(tx_flushing == 1, "R12 flush bit held until empty seen", tx_flushing, 1);
    cyc();
    chk(tx_flushing == 0, "R12 flush bit self-clears", tx_flushing, 0);
    slot();
    chk(ser_tx_sample == 16'h021F && underrun_flag, "R12 flushed and in-flush write lost", ser_tx_sample, 16'h021F);
    clr_underrun = 1; cyc(); clr_underrun = 0;

    // R2/R9 new threshold
    set_thr(4'd2, 4'd3);
    for (int i = 0; i < 3; i++) wr_tx(16'h0400 + 16'(i));
    chk(tx_dma_req == 0, "R9 level 3 above threshold 2", tx_dma_req, 0);
    slot();
    chk(tx_dma_req == 1, "R9 level 2 at threshold 2", tx_dma_req, 1);

    // R6/R10 receive path
    set_ctl(1, 1, 1, 1, 1, 4'b0100);
    rx_in(16'h0500); rx_in(16'h0501);
    chk(rx_dma_req == 0, "R10 level 2 below threshold 3", rx_dma_req, 0);
    rx_in(16'h0502);
    chk(rx_dma_req == 1 && irq == 1, "R10 level 3 at threshold, R11 rx service irq", rx_dma_req, 1);
    rd();
    chk(bus_rd_data == 16'h0500, "R6 oldest receive word", bus_rd_data, 16'h0500);
    rd(); rd(); rd();
    chk(bus_rd_data == 0, "R6 empty read returns 0", bus_rd_data, 0);
    set_thr(4'd2, 4'd0);
    chk(rx_dma_req == 0, "R10 threshold 0 with empty FIFO no request", rx_dma_req, 0);

    // R7 overrun
    set_thr(4'd2, 4'd7);
    for (int i = 0; i < 33; i++) rx_in(16'h0600 + 16'(i));
    chk(overrun_flag == 1, "R7 overrun flag", overrun_flag, 1);
    set_ctl(1, 1, 1, 1, 1, 4'b0001);
    chk(irq == 1, "R11 overrun irq bit0", irq, 1);
    for (int i = 0; i < 32; i++) rd();
    chk(bus_rd_data == 16'h061F, "R7 extra sample dropped", bus_rd_data, 16'h061F);
    clr_overrun = 1; cyc(); clr_overrun = 0;
    chk(overrun_flag == 0, "R8 overrun clear", overrun_flag, 0);

    // R1 cfg_reset overrides a same-cycle write
    wr_tx(16'h0700);
    cfg_tx_en = 1; cfg_tx_dma_en = 1; cfg_ctl_we = 1; cfg_reset = 1;
    cyc(); cfg_ctl_we = 0; cfg_reset = 0;
    chk(tx_dma_req == 0 && ser_tx_sample == 0, "R1 cfg_reset wins over ctl write", tx_dma_req, 0);

    // R13 shared flush variant
    set_ctl(0, 1, 0, 1, 0, 4'b0000);
    for (int i = 0; i < 10; i++) rx_in(16'h0800 + 16'(i));
    chk(s_rx_dma_req == 1, "R13 shared instance rx request before flush", s_rx_dma_req, 1);
    rx_flush_cmd = 1; cyc(); rx_flush_cmd = 0;
    cyc(2);
    chk(s_rx_flushing == 0 && s_rx_dma_req == 1, "R13 rx flush command ignored", s_rx_dma_req, 1);
    tx_flush_cmd = 1; cyc(); tx_flush_cmd = 0;
    chk(s_rx_flushing == 1, "R13 tx flush sets rx flush", s_rx_flushing, 1);
    cyc(2);
    chk(s_rx_dma_req == 0 && s_rx_flushing == 0, "R13 rx emptied by tx flush", s_rx_dma_req, 0);
    rd();
    chk(s_bus_rd_data == 0, "R13 shared rx reads empty", s_bus_rd_data, 0);

    cyc(2);
    finish_run();
  end

endmodule